// File: doc/BRIEF.md
# Narrow-to-Wide Packing Write Bridge

This block takes a stream of 32-bit data beats, offered with valid, ready and an end-of-transfer marker, and packs them into 128-bit words for a wide memory write port. Each group of four accepted beats becomes one wide write with every byte enabled. When a transfer ends before a group is full, the bridge writes the lanes it has, with only their bytes enabled. The memory port has no back-pressure; the bridge holds its input ready low for the one cycle in which it presents a write.

Each write goes to the next 16-byte slot after the previous one, starting from a base address set by a parameter. A sticky completion flag goes high once the final beat of a transfer has been accepted. A downstream protocol sequencer can wait on it to know that the payload has landed in memory. Only reset or a dedicated clear input brings the flag back down.

Top module: `wide_pack_bridge`

## Requirements
- R1: Beats are packed little-endian: the first accepted beat of a word sits in bits [31:0], the second in [63:32], the third in [95:64] and the fourth in [127:96].
- R2: After the fourth beat of a word is accepted, `wrValid` is high for exactly one cycle, starting in the cycle after that acceptance edge, with `wrBe` = 16'hFFFF.
- R3: `beatReady` is low in every cycle in which `wrValid` is high, and high in every other cycle after reset.
- R4: When a beat marked with `beatLast` is accepted as beat k of a word (k = 1, 2 or 3), one write follows in the next cycle. Its `wrBe` has the low 4*k bits set, and its data bits above 32*k are zero.
- R5: `payloadDone` goes high in the cycle after a beat with `beatLast` is accepted. It stays high until a clear or a reset. A set and a clear in the same cycle leave it high.
- R6: The first write after reset uses address BASE_ADDR. Every write, full or partial, advances the next address by 16.
- R7: After any write, including a partial one, the next accepted beat goes to bits [31:0] of a fresh word.
- R8: During and right after reset, `wrValid` is low, `beatReady` is high and `payloadDone` is low.
- R9: A cycle with `doneClear` high and no accepted last beat drives `payloadDone` low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| beatValid | input | 1 | Input beat is offered |
| beatData | input | 32 | Input beat payload |
| beatLast | input | 1 | Offered beat ends the transfer |
| beatReady | output | 1 | Bridge accepts a beat this cycle |
| doneClear | input | 1 | Clears the completion flag |
| wrValid | output | 1 | Wide write presented this cycle |
| wrAddr | output | 32 | Byte address of the wide write |
| wrData | output | 128 | Wide write data |
| wrBe | output | 16 | Byte enables of the wide write |
| payloadDone | output | 1 | Sticky flag: final beat of a transfer accepted |

## Verification
Directed cases first send one full group of four beats, then transfers of one, two and three beats. These show full packing apart from each partial byte-enable width, and show that the lane position restarts after a short word. Random stimulus then mixes idle cycles, offers made while ready is low, early last beats and clear pulses. This exposes any beat taken during the write cycle, any lost or duplicated beat and any address skew over many words. Clear pulses placed in the same cycle as a last beat separate set-over-clear priority from plain clearing.

// File: rtl/wide_pack_pkg.sv
package wide_pack_pkg;

  // Upper bound on lane-select width carried in the strobe struct.
  localparam int LANE_SEL_W = 4;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_EMIT    = 1'b1
  } packState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  capture;    // store beat into selected lane
    logic [LANE_SEL_W-1:0] laneSel;    // lane receiving the beat
    logic                  lastAccept; // accepted beat ends the transfer
    logic                  emitting;   // write is on the port this cycle
  } packStrobe_t;

endpackage

// File: rtl/wide_pack_ctrl.sv
module wide_pack_ctrl
  import wide_pack_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        beatValid,
  input  logic        beatLast,
  output logic        beatReady,
  output logic        wrValid,
  output packStrobe_t strb
);

  localparam int LANE_IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_IDX_W-1:0] LAST_LANE = LANE_IDX_W'(LANES - 1);

  packState_e             state, stateNext;
  logic [LANE_IDX_W-1:0]  laneCnt, laneCntNext;
  logic                   accept;

  assign accept    = beatValid && (state == ST_COLLECT);
  assign beatReady = (state == ST_COLLECT);
  assign wrValid   = (state == ST_EMIT);

  always_comb begin
    stateNext   = state;
    laneCntNext = laneCnt;
    if (state == ST_EMIT) begin
      stateNext   = ST_COLLECT;
      laneCntNext = '0;
    end else if (accept) begin
      if (beatLast || laneCnt == LAST_LANE) begin
        stateNext = ST_EMIT;
      end else begin
        laneCntNext = laneCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_COLLECT;
      laneCnt <= '0;
    end else begin
      state   <= stateNext;
      laneCnt <= laneCntNext;
    end
  end

  always_comb begin
    strb            = '0;
    strb.capture    = accept;
    strb.laneSel    = LANE_SEL_W'(laneCnt);
    strb.lastAccept = accept && beatLast;
    strb.emitting   = (state == ST_EMIT);
  end

  // R2: a write lasts one cycle only
  p_single_emit_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  // R2: filling the top lane is followed by a write
  p_full_then_emit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && laneCnt == LAST_LANE) |=> wrValid);

  // R4: an early last beat is followed by a write
  p_last_then_emit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatReady && beatLast) |=> wrValid);

  // R7: lane counter is zero after any write
  p_lane_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> (laneCnt == '0));

endmodule

// File: rtl/wide_pack_dp.sv
module wide_pack_dp
  import wide_pack_pkg::*;
#(
  parameter int              NARROW_W  = 32,
  parameter int              LANES     = 4,
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  packStrobe_t                  strb,
  input  logic [NARROW_W-1:0]          beatData,
  input  logic                         doneClear,
  output logic [ADDR_W-1:0]            wrAddr,
  output logic [NARROW_W*LANES-1:0]    wrData,
  output logic [NARROW_W*LANES/8-1:0]  wrBe,
  output logic                         payloadDone
);

  localparam int WIDE_W     = NARROW_W * LANES;
  localparam int BE_W       = WIDE_W / 8;
  localparam int LANE_BYTES = NARROW_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BE_W);

  logic [WIDE_W-1:0] wordBuf;
  logic [BE_W-1:0]   beBuf;
  logic [ADDR_W-1:0] addrReg;
  logic              doneReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic laneHit;
    assign laneHit = strb.capture && (strb.laneSel == LANE_SEL_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN || strb.emitting) begin
        wordBuf[g*NARROW_W +: NARROW_W] <= '0;
        beBuf[g*LANE_BYTES +: LANE_BYTES] <= '0;
      end else if (laneHit) begin
        wordBuf[g*NARROW_W +: NARROW_W] <= beatData;
        beBuf[g*LANE_BYTES +: LANE_BYTES] <= '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= BASE_ADDR;
    end else if (strb.emitting) begin
      addrReg <= addrReg + ADDR_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneReg <= 1'b0;
    end else if (strb.lastAccept) begin
      doneReg <= 1'b1;
    end else if (doneClear) begin
      doneReg <= 1'b0;
    end
  end

  assign wrAddr      = addrReg;
  assign wrData      = wordBuf;
  assign wrBe        = beBuf;
  assign payloadDone = doneReg;

  // R6: address steps by one wide word per write
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitting |=> (wrAddr == $past(wrAddr) + ADDR_STEP));

  // R4: byte enables of a write are a nonzero run from bit 0
  p_be_low_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.emitting |-> ((wrBe != '0) && ((wrBe & (wrBe + 1'b1)) == '0)));

  // R5: flag rises after an accepted last beat
  p_done_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastAccept |=> payloadDone);

  // R5: flag holds without a clear
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (payloadDone && !doneClear) |=> payloadDone);

  // R9: a clear without a last beat drops the flag
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneClear && !strb.lastAccept) |=> !payloadDone);

endmodule

// File: rtl/wide_pack_bridge.sv
module wide_pack_bridge
  import wide_pack_pkg::*;
#(
  parameter int              NARROW_W  = 32,
  parameter int              LANES     = 4,
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_1000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         beatValid,
  input  logic [NARROW_W-1:0]          beatData,
  input  logic                         beatLast,
  output logic                         beatReady,
  input  logic                         doneClear,
  output logic                         wrValid,
  output logic [ADDR_W-1:0]            wrAddr,
  output logic [NARROW_W*LANES-1:0]    wrData,
  output logic [NARROW_W*LANES/8-1:0]  wrBe,
  output logic                         payloadDone
);

  packStrobe_t strb;

  wide_pack_ctrl #(
    .LANES(LANES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .beatValid (beatValid),
    .beatLast  (beatLast),
    .beatReady (beatReady),
    .wrValid   (wrValid),
    .strb      (strb)
  );

  wide_pack_dp #(
    .NARROW_W  (NARROW_W),
    .LANES     (LANES),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .beatData    (beatData),
    .doneClear   (doneClear),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .wrBe        (wrBe),
    .payloadDone (payloadDone)
  );

  // R3: no beat is taken while a write is presented
  p_ready_low_emit_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !beatReady);

endmodule

// File: tb/tb_wide_pack_bridge.sv
module tb_wide_pack_bridge;

  localparam logic [31:0] BASE = 32'h0000_1000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         beatValid;
  logic [31:0]  beatData;
  logic         beatLast;
  logic         beatReady;
  logic         doneClear;
  logic         wrValid;
  logic [31:0]  wrAddr;
  logic [127:0] wrData;
  logic [15:0]  wrBe;
  logic         payloadDone;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [127:0] mBuf;
  int           mLane;
  logic [31:0]  mAddr;
  bit           eEmit;
  logic [127:0] eData;
  logic [15:0]  eBe;
  bit           eDone;
  bit           ePartial;
  bit           afterPartial;
  bit           eAfterPartial;

  always #4 clk = ~clk;  // 125 MHz

  wide_pack_bridge #(.BASE_ADDR(BASE)) dut (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatData(beatData),
    .beatLast(beatLast), .beatReady(beatReady), .doneClear(doneClear),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrBe(wrBe),
    .payloadDone(payloadDone)
  );

  function automatic logic [15:0] beFor(int k);
    logic [16:0] m;
    m = (17'd1 << (4 * k)) - 17'd1;
    return m[15:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Check outputs at the falling edge, then drive the next cycle's inputs.
  task automatic step(bit v, logic [31:0] d, bit l, bit c);
    bit acc;
    bit nEmit;
    @(negedge clk);
    chk(wrValid == eEmit, "R2 R4 wrValid", 128'(wrValid), 128'(eEmit));
    chk(beatReady == !eEmit, "R3 beatReady", 128'(beatReady), 128'(!eEmit));
    chk(payloadDone == eDone, "R5 R9 payloadDone", 128'(payloadDone), 128'(eDone));
    if (eEmit && wrValid) begin
      chk(wrAddr == mAddr, "R6 wrAddr", 128'(wrAddr), 128'(mAddr));
      chk(wrBe == eBe, ePartial ? "R4 wrBe" : "R2 wrBe", 128'(wrBe), 128'(eBe));
      chk(wrData == eData, eAfterPartial ? "R7 wrData" : (ePartial ? "R4 wrData" : "R1 wrData"),
          wrData, eData);
    end
    beatValid = v;
    beatData  = d;
    beatLast  = l;
    doneClear = c;
    acc   = v && beatReady;
    nEmit = 1'b0;
    if (eEmit) begin
      mAddr = mAddr + 32'd16;
      mBuf  = '0;
      mLane = 0;
    end else if (acc) begin
      mBuf[mLane*32 +: 32] = d;
      mLane++;
      if (mLane == 4 || l) begin
        nEmit         = 1'b1;
        eData         = mBuf;
        eBe           = beFor(mLane);
        ePartial      = (mLane < 4);
        eAfterPartial = afterPartial;
        afterPartial  = (mLane < 4);
      end
    end
    if (acc && l) eDone = 1'b1;
    else if (c)   eDone = 1'b0;
    eEmit = nEmit;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0_ffee));
    rstN = 1'b0; beatValid = 1'b0; beatData = '0; beatLast = 1'b0; doneClear = 1'b0;
    mBuf = '0; mLane = 0; mAddr = BASE; eEmit = 0; eData = '0; eBe = '0;
    eDone = 0; ePartial = 0; afterPartial = 0; eAfterPartial = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset values
    chk(wrValid == 1'b0, "R8 wrValid", 128'(wrValid), 128'(0));
    chk(beatReady == 1'b1, "R8 beatReady", 128'(beatReady), 128'(1));
    chk(payloadDone == 1'b0, "R8 payloadDone", 128'(payloadDone), 128'(0));
    rstN = 1'b1;

    // R1 R2: one full word
    step(1, 32'h1111_0000, 0, 0);
    step(1, 32'h2222_0001, 0, 0);
    step(1, 32'h3333_0002, 0, 0);
    step(1, 32'h4444_0003, 1, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R9: clear flag
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    // R4: partial words of 1, 2 and 3 beats, then R7 a full word
    step(1, 32'hAAAA_0001, 1, 0);
    step(1, 32'hBBBB_0001, 0, 0);
    step(1, 32'hBBBB_0002, 1, 0);
    step(1, 32'hCCCC_0001, 0, 0);
    step(1, 32'hCCCC_0002, 0, 0);
    step(1, 32'hCCCC_0003, 1, 0);
    step(1, 32'hDDDD_0001, 0, 0);
    step(1, 32'hDDDD_0002, 0, 0);
    step(1, 32'hDDDD_0003, 0, 0);
    step(1, 32'hDDDD_0004, 0, 1);
    // R5: clear in same cycle as last beat, set wins
    step(1, 32'hEEEE_0001, 1, 1);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit v, l, c;
      v = ($urandom % 4) != 0;
      l = ($urandom % 6) == 0;
      c = ($urandom % 9) == 0;
      step(v, $urandom, l, c);
    end
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule